// File: doc/BRIEF.md
# SPI Register Access Target

This block is an SPI target that gives an external master byte-wide access to a bank of registers. The master opens a transaction by pulling chip select low and clocks a command byte. The command byte holds a direction bit, an auto-increment bit and a 6-bit register address. One or more data bytes follow. On the register side the block presents an address, write data, a one-cycle write strobe and a read-data input. The register file is not part of the block and answers combinationally from the presented address.

The serial pins are asynchronous to the block. Chip select, serial clock and serial data are passed through synchronizer stages on the faster system clock, and the serial clock edges are found from the synchronized samples. A static configuration input chooses between two wiring modes. In 4-wire mode, read data leaves on a dedicated output pin. In 3-wire mode, read data is driven back onto the shared data pin, and an output enable controls the tristate driver.

The controller has four states. `ST_IDLE` is the state while chip select is high. `ST_CMD` is entered from idle when chip select goes low, and collects the command byte. When the eighth command bit has been captured, `ST_CMD` moves to `ST_WDATA` if the direction bit is 0, or to `ST_RDATA` if it is 1. Both data states hold until chip select rises. A rising chip select returns any state to `ST_IDLE`.

Top module: `spi_regif_slave`

## Requirements
- R1: Reset behaviour. While reset is held and after it is released, with chip select high, both output enables and the write strobe are low.
- R2: Command byte layout. The command byte is received MSB first and its bit order is fixed. The first bit on the wire is the direction: 1 means read and 0 means write. The second bit is the auto-increment enable. The last six bits are the register address, MSB first.
- R3: Write strobe. In a write transaction, every complete 8-bit data byte produces exactly one single-cycle `reg_we` pulse. During that pulse, `reg_wdata` holds the byte and `reg_addr` holds the address that applies to that byte.
- R4: Address stepping. When auto-increment is 1, the address advances by one after each data byte, in both reads and writes, and wraps from 63 to 0. When auto-increment is 0, every data byte uses the command address.
- R5: Read data. In a read, data is sampled on the serial clock rising edge and launched on the falling edge. The first data bit appears at the falling edge that begins bit 8. Each byte is the MSB-first value of `reg_rdata` at the byte's address.
- R6: 4-wire mode (`three_wire`=0). Read data leaves on `spi_sdo` with `spi_sdo_oe` high, and `spi_sdi_oe` stays low.
- R7: 3-wire mode (`three_wire`=1). Read data leaves on `spi_sdi_out` with `spi_sdi_oe` high, and `spi_sdo_oe` stays low. Write data is taken from the same shared pin.
- R8: Early termination. Chip select rising at any point ends the transaction and drops both output enables. An incomplete data byte produces no write strobe and leaves the register unchanged.
- R9: Output enables during other phases. Neither output enable is asserted during the command byte or during any write transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| three_wire | input | 1 | 1 selects 3-wire mode, 0 selects 4-wire mode |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idles high |
| spi_sdi | input | 1 | Serial data in (the shared data pin in 3-wire mode) |
| spi_sdo | output | 1 | Serial data out, 4-wire mode |
| spi_sdo_oe | output | 1 | Output enable for spi_sdo |
| spi_sdi_out | output | 1 | Data driven onto the shared pin in 3-wire mode |
| spi_sdi_oe | output | 1 | Output enable for the shared pin |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | DATA_W | Register write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | DATA_W | Read data from the register file at reg_addr |

## Verification
The bench targets auto-increment bursts that cross address 63. A design that stepped the address before the strobe, or did not wrap, would write to the wrong location or out of range. A read whose first data bit is checked on the ninth rising edge would catch a launch one bit early or late. A fixed-address burst would catch a block that incremented regardless of the command bit. Transactions cut off mid-byte, both in a write and in a read, must leave no extra strobe and no driven pin after chip select rises. The two wiring modes are run back to back to show that read data never appears on the wrong pin.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMD   = 2'd1,
        ST_WDATA = 2'd2,
        ST_RDATA = 2'd3
    } spi_state_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_pin,
    input  logic sck_pin,
    input  logic sdi_pin,
    output logic cs_n_s,
    output logic sdi_s,
    output logic sck_rise,
    output logic sck_fall
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] cs_pipe;
    logic [SYNC_STAGES-1:0] sck_pipe;
    logic [SYNC_STAGES-1:0] sdi_pipe;
    logic                   sck_prev;

    // All three pins go through equal-length pipes so data stays aligned to clock edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_pipe  <= '1;
            sck_pipe <= '1;
            sdi_pipe <= '0;
            sck_prev <= 1'b1;
        end else begin
            cs_pipe  <= {cs_pipe[TOP-1:0], cs_n_pin};
            sck_pipe <= {sck_pipe[TOP-1:0], sck_pin};
            sdi_pipe <= {sdi_pipe[TOP-1:0], sdi_pin};
            sck_prev <= sck_pipe[TOP];
        end
    end

    always_comb begin
        cs_n_s   = cs_pipe[TOP];
        sdi_s    = sdi_pipe[TOP];
        sck_rise = !cs_n_s &&  sck_pipe[TOP] && !sck_prev;
        sck_fall = !cs_n_s && !sck_pipe[TOP] &&  sck_prev;
    end

endmodule

// File: rtl/spi_txn_fsm.sv
module spi_txn_fsm
    import spi_regif_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sdi_s,
    input  logic              sck_rise,
    input  logic              sck_fall,
    output spi_state_e        state,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              tx_load,
    output logic              tx_shift
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam int RW_BIT = DATA_W - 1;
    localparam int MS_BIT = DATA_W - 2;

    spi_state_e        state_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] byte_in;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              ms_q;
    logic              we_q;
    logic              inc_q;
    logic              byte_done;
    logic              in_data;

    always_comb begin
        byte_in   = {rx_sh[DATA_W-2:0], sdi_s};
        byte_done = sck_rise && (bit_cnt == LAST_BIT);
        in_data   = (state == ST_WDATA) || (state == ST_RDATA);
    end

    // Next-state logic
    always_comb begin
        state_d = state;
        if (cs_n_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_d = ST_CMD;
                ST_CMD:   if (byte_done) state_d = byte_in[RW_BIT] ? ST_RDATA : ST_WDATA;
                ST_WDATA: state_d = ST_WDATA;
                ST_RDATA: state_d = ST_RDATA;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Bit counter, receive shifter, address and write capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            ms_q    <= 1'b0;
            we_q    <= 1'b0;
            inc_q   <= 1'b0;
        end else begin
            we_q  <= 1'b0;
            inc_q <= 1'b0;
            if (cs_n_s) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                rx_sh   <= byte_in;
                bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
            end
            if (state == ST_CMD && byte_done) begin
                ms_q   <= byte_in[MS_BIT];
                addr_q <= byte_in[ADDR_W-1:0];
            end
            if (state == ST_WDATA && byte_done) begin
                we_q    <= 1'b1;
                wdata_q <= byte_in;
            end
            // Step one cycle after the byte, so the strobe still sees the old address
            if (in_data && byte_done && ms_q) inc_q <= 1'b1;
            if (inc_q) addr_q <= addr_q + ADDR_W'(1);
        end
    end

    // Outputs
    always_comb begin
        reg_addr  = addr_q;
        reg_wdata = wdata_q;
        reg_we    = we_q;
        tx_load   = (state == ST_RDATA) && sck_fall && (bit_cnt == '0);
        tx_shift  = (state == ST_RDATA) && sck_fall && (bit_cnt != '0);
    end

    assert_cs_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> state == ST_IDLE);

    assert_we_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    assert_we_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(state) == ST_WDATA);

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && ms_q) |=> reg_addr == $past(reg_addr) + ADDR_W'(1));

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !ms_q) |=> $stable(reg_addr));

endmodule

// File: rtl/spi_tx_path.sv
module spi_tx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              three_wire,
    input  logic              tx_load,
    input  logic              tx_shift,
    input  logic [DATA_W-1:0] rdata,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              sdi_out,
    output logic              sdi_oe
);
    logic [DATA_W-1:0] tx_sh;
    logic              active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            active <= 1'b0;
        end else begin
            if (tx_load)       tx_sh <= rdata;
            else if (tx_shift) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            if (cs_n_s)        active <= 1'b0;
            else if (tx_load)  active <= 1'b1;
        end
    end

    always_comb begin
        sdo     = tx_sh[DATA_W-1];
        sdi_out = tx_sh[DATA_W-1];
        sdo_oe  = active && !three_wire;
        sdi_oe  = active &&  three_wire;
    end

    assert_drive_starts_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(tx_load));

    assert_drive_ends_on_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !(sdo_oe || sdi_oe));

endmodule

// File: rtl/spi_regif_slave.sv
module spi_regif_slave
    import spi_regif_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              three_wire,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    output logic              spi_sdo_oe,
    output logic              spi_sdi_out,
    output logic              spi_sdi_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic       cs_n_s;
    logic       sdi_s;
    logic       sck_rise;
    logic       sck_fall;
    logic       tx_load;
    logic       tx_shift;
    spi_state_e state;

    spi_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_pin (spi_cs_n),
        .sck_pin  (spi_sck),
        .sdi_pin  (spi_sdi),
        .cs_n_s   (cs_n_s),
        .sdi_s    (sdi_s),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    spi_txn_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .sdi_s     (sdi_s),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .state     (state),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .tx_load   (tx_load),
        .tx_shift  (tx_shift)
    );

    spi_tx_path #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_s     (cs_n_s),
        .three_wire (three_wire),
        .tx_load    (tx_load),
        .tx_shift   (tx_shift),
        .rdata      (reg_rdata),
        .sdo        (spi_sdo),
        .sdo_oe     (spi_sdo_oe),
        .sdi_out    (spi_sdi_out),
        .sdi_oe     (spi_sdi_oe)
    );

    assert_oe_read_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sdo_oe || spi_sdi_oe) |-> state == ST_RDATA);

    assert_no_strobe_in_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sdo_oe || spi_sdi_oe) |-> !reg_we);

endmodule

// File: tb/spi_regif_slave_bench.sv
`timescale 1ns/1ps
module spi_regif_slave_bench;
    localparam int HALF = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       three_wire = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_sck = 1'b1;
    logic       mst_sdi = 1'b0;
    logic       sdi_line;
    logic       spi_sdo, spi_sdo_oe, spi_sdi_out, spi_sdi_oe;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;

    logic [7:0]  mem [64];
    logic [7:0]  exp_mem [64];
    logic [13:0] wq [$];
    logic [7:0]  tx_bytes [8];
    logic [7:0]  rx_bytes [8];
    logic        oe_in_cmd, oe_missing, oe_wrong_pin;
    int          n_checks = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    assign sdi_line  = spi_sdi_oe ? spi_sdi_out : mst_sdi;
    assign reg_rdata = mem[reg_addr];

    spi_regif_slave u_spi_regif_slave (
        .clk(clk), .rst_n(rst_n), .three_wire(three_wire),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_sdi(sdi_line),
        .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
        .spi_sdi_out(spi_sdi_out), .spi_sdi_oe(spi_sdi_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata)
    );

    always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: compare every strobe against the next expected write
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (wq.size() == 0) begin
                check(1'b0, "R3/R8", "unexpected write strobe", {18'd0, reg_addr, reg_wdata}, 32'd0);
            end else begin
                logic [13:0] e;
                e = wq.pop_front();
                check({reg_addr, reg_wdata} == e, "R3/R4", "write addr/data",
                      {18'd0, reg_addr, reg_wdata}, {18'd0, e});
            end
        end
    end

    task automatic run_txn(input logic rw, input logic ms, input logic [5:0] a,
                           input int nbytes, input int tail_bits);
        logic [7:0] cmd;
        logic       bv;
        int         total;
        cmd = {rw, ms, a};
        total = 8 + 8 * nbytes + tail_bits;
        oe_in_cmd = 1'b0; oe_missing = 1'b0; oe_wrong_pin = 1'b0;
        spi_cs_n = 1'b0;
        #HALF;
        for (int b = 0; b < total; b++) begin
            spi_sck = 1'b0;
            if (b < 8)    mst_sdi = cmd[7 - b];
            else if (!rw) mst_sdi = tx_bytes[(b - 8) / 8][7 - ((b - 8) % 8)];
            else          mst_sdi = 1'b0;
            #HALF;
            spi_sck = 1'b1;
            if (b < 8 || !rw) begin
                if (spi_sdo_oe || spi_sdi_oe) oe_in_cmd = 1'b1;
            end else begin
                bv = three_wire ? spi_sdi_out : spi_sdo;
                rx_bytes[(b - 8) / 8][7 - ((b - 8) % 8)] = bv;
                if (three_wire ? !spi_sdi_oe : !spi_sdo_oe) oe_missing = 1'b1;
                if (three_wire ?  spi_sdo_oe :  spi_sdi_oe) oe_wrong_pin = 1'b1;
            end
            #HALF;
        end
        spi_cs_n = 1'b1;
        #(HALF * 2);
    endtask

    task automatic do_write(input logic ms, input logic [5:0] a, input int n, input int tail);
        logic [5:0] ea;
        for (int j = 0; j < n; j++) begin
            ea = ms ? a + 6'(j) : a;
            wq.push_back({ea, tx_bytes[j]});
            exp_mem[ea] = tx_bytes[j];
        end
        run_txn(1'b0, ms, a, n, tail);
        check(wq.size() == 0, "R3", "all expected strobes seen", wq.size(), 0);
        check(!oe_in_cmd, "R9", "no output enable in write", oe_in_cmd, 0);
    endtask

    task automatic do_read(input logic ms, input logic [5:0] a, input int n, input string req);
        logic [5:0] ea;
        run_txn(1'b1, ms, a, n, 0);
        for (int j = 0; j < n; j++) begin
            ea = ms ? a + 6'(j) : a;
            check(rx_bytes[j] == exp_mem[ea], req, "read byte", rx_bytes[j], exp_mem[ea]);
        end
        check(!oe_in_cmd, "R9", "no output enable during command", oe_in_cmd, 0);
        check(!oe_missing, "R5", "drive from bit 8 onward", oe_missing, 0);
        check(!oe_wrong_pin, three_wire ? "R7" : "R6", "unused pin stays released", oe_wrong_pin, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i]     = 8'(i * 37 + 11);
            exp_mem[i] = 8'(i * 37 + 11);
        end
        repeat (4) @(posedge clk);
        #1;
        check(!spi_sdo_oe && !spi_sdi_oe && !reg_we, "R1", "idle during reset",
              {spi_sdo_oe, spi_sdi_oe, reg_we}, 0);
        rst_n = 1'b1;
        repeat (6) @(posedge clk);
        #1;
        check(!spi_sdo_oe && !spi_sdi_oe && !reg_we, "R1", "idle after reset",
              {spi_sdo_oe, spi_sdi_oe, reg_we}, 0);

        // R2 R3: single write, 4-wire
        tx_bytes[0] = 8'hA5;
        do_write(1'b0, 6'h15, 1, 0);
        // R4: auto-increment burst wrapping 63 -> 0
        tx_bytes[0] = 8'h11; tx_bytes[1] = 8'h22; tx_bytes[2] = 8'h33;
        do_write(1'b1, 6'h3E, 3, 0);
        // R4: fixed address burst
        tx_bytes[0] = 8'h5A; tx_bytes[1] = 8'hC3;
        do_write(1'b0, 6'h08, 2, 0);

        // R5 R6: reads in 4-wire mode
        do_read(1'b0, 6'h15, 1, "R5");
        do_read(1'b1, 6'h3E, 3, "R4");
        do_read(1'b0, 6'h08, 2, "R4");
        do_read(1'b1, 6'h02, 2, "R2");

        // R7: 3-wire mode read and write on the shared pin
        three_wire = 1'b1;
        #(HALF * 2);
        do_read(1'b0, 6'h21, 1, "R7");
        tx_bytes[0] = 8'h96;
        do_write(1'b0, 6'h21, 1, 0);
        do_read(1'b1, 6'h20, 3, "R7");
        three_wire = 1'b0;
        #(HALF * 2);

        // R8: write cut off mid-byte: one strobe only, next register untouched
        tx_bytes[0] = 8'hE7; tx_bytes[1] = 8'h0F;
        do_write(1'b1, 6'h30, 1, 5);
        do_read(1'b0, 6'h31, 1, "R8");
        // R8: read cut off mid-byte: drive released after chip select rises
        run_txn(1'b1, 1'b0, 6'h15, 0, 4);
        check(!oe_missing, "R8", "drive active before cut", oe_missing, 0);
        check(!spi_sdo_oe && !spi_sdi_oe, "R8", "drive released after cut",
              {spi_sdo_oe, spi_sdi_oe}, 0);
        do_read(1'b0, 6'h15, 1, "R8");

        check(wq.size() == 0, "R3", "scoreboard empty at end", wq.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule